// File: doc/BRIEF.md
# Cache Port Write Front End with Early Response and Line Zeroing

This block sits at the write side of a cache controller port. It takes AXI write address, write data and write response traffic and turns each transaction into commands for an internal store buffer. A normal transaction becomes one address-open command followed by one beat command per data beat. Each beat command carries that beat's address, data and byte strobes.

Two optional behaviours break ordinary AXI rules. Each is armed by a bit of an auxiliary control register and then requested per transaction by a bit of the write address user sideband. The line-zeroing behaviour replaces the whole transaction with a single command that clears one 32-byte cache line. The early-response behaviour returns the write response as soon as the store buffer takes the address command, before the data has arrived.

The block also holds a lockdown register. Secure writes to it always take effect. Non-secure writes take effect only when the auxiliary register allows them.

Top module: `axi_wr_early_port`

## Requirements
- R1: After reset the auxiliary register and the lockdown register read zero, `bvalid` is low and `awready` is high.
- R2: A configuration write with `cfg_sel`=0 loads the auxiliary register, which reads back on `aux_ctrl`. Its bit 0 arms line zeroing, bit 30 arms early response and bit 26 opens the lockdown register to non-secure writes.
- R3: When aux bit 0 is set and `awuser[10]` is 1, the transaction produces exactly one store-buffer command. That command has op code 2 (zero), an address aligned down to a 32-byte boundary, data 0 and all strobes set. Length, size, data and strobes of the transaction are ignored.
- R4: A line-zero transaction still accepts every write data beat up to and including WLAST, and it issues no beat command for them.
- R5: A normal transaction first issues op code 0 (open) carrying AWADDR. It then issues op code 1 (beat) once per data beat, carrying WDATA, WSTRB and the beat address. The first beat address is AWADDR. Each later beat address is the previous one aligned down to 2^AWSIZE bytes, plus 2^AWSIZE.
- R6: Without early response, `bvalid` first rises in the cycle after the WLAST handshake.
- R7: When aux bit 30 is set and `awuser[11]` is 1, `bvalid` first rises in the cycle after the store buffer accepts the open or zero command. Exactly one response is returned for the transaction.
- R8: A set user bit has no effect while its auxiliary enable bit is clear. The transaction then behaves as in R5 and R6.
- R9: BID equals the AWID of the transaction, BRESP is 0 (OKAY), and `bvalid` with `bid` holds until `bready`.
- R10: Only one transaction is open at a time. `awready` stays low from the address handshake until the last data beat is accepted and the response has been taken.
- R11: A configuration write with `cfg_sel`=1 loads the lockdown register when `cfg_nonsec` is 0. When `cfg_nonsec` is 1, it loads the register only if aux bit 26 is set, and otherwise leaves it unchanged.
- R12: While `sb_valid` is high and `sb_ready` is low, `sb_valid`, `sb_op` and `sb_addr` hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 1 | 0 selects auxiliary register, 1 selects lockdown register |
| cfg_nonsec | input | 1 | Write comes from the non-secure state |
| cfg_wdata | input | 32 | Configuration write data |
| aux_ctrl | output | 32 | Auxiliary control register value |
| lockdown | output | LOCK_W | Lockdown register value |
| awvalid | input | 1 | Write address valid |
| awready | output | 1 | Write address ready |
| awid | input | ID_W | Transaction ID |
| awaddr | input | ADDR_W | Start address |
| awlen | input | 8 | Beats minus one |
| awsize | input | 3 | Log2 of beat bytes |
| awuser | input | USER_W | Sideband; bit 10 requests zeroing, bit 11 requests early response |
| wvalid | input | 1 | Write data valid |
| wready | output | 1 | Write data ready |
| wdata | input | DATA_W | Write data |
| wstrb | input | DATA_W/8 | Byte strobes |
| wlast | input | 1 | Last beat |
| bvalid | output | 1 | Response valid |
| bready | input | 1 | Response ready |
| bid | output | ID_W | Response ID |
| bresp | output | 2 | Response code |
| sb_valid | output | 1 | Store-buffer command valid |
| sb_ready | input | 1 | Store-buffer command ready |
| sb_op | output | 2 | 0 open, 1 beat, 2 zero line |
| sb_addr | output | ADDR_W | Command address |
| sb_data | output | DATA_W | Beat data |
| sb_strb | output | DATA_W/8 | Beat strobes |

## Verification
The bench builds the block with its defaults: 64-bit data, 32-bit addresses, 4-bit IDs, a 12-bit user field and a 32-byte line. The 64-bit data width lets AWSIZE range from 0 to 3, so it covers both narrow and full-width beat address stepping. The 32-byte line is four beats wide, so a zero command's alignment must clear five address bits that random start addresses often set. The 12-bit user field holds both request bits, so every mix of enabled and disabled optimizations, with and without the user bit, can be reached under random ready patterns on both the store buffer and the response channel.

// File: rtl/wport_pkg.sv
package wport_pkg;
   typedef enum logic [1:0] {
      SB_OPEN = 2'd0,
      SB_BEAT = 2'd1,
      SB_ZERO = 2'd2
   } sb_op_e;

   localparam int AUX_ZERO_BIT   = 0;
   localparam int AUX_NSLOCK_BIT = 26;
   localparam int AUX_EARLY_BIT  = 30;
   localparam int USR_ZERO_BIT   = 10;
   localparam int USR_EARLY_BIT  = 11;
   localparam logic [1:0] BRESP_OKAY = 2'b00;

   function automatic logic [31:0] aux_wmask_f(input bit has_zero, input bit has_early);
      logic [31:0] m;
      m = '1;
      if (!has_zero)  m[AUX_ZERO_BIT]  = 1'b0;
      if (!has_early) m[AUX_EARLY_BIT] = 1'b0;
      return m;
   endfunction
endpackage

// File: rtl/wport_cfg_regs.sv
module wport_cfg_regs
   import wport_pkg::*;
#(
   parameter int LOCK_W    = 16,
   parameter bit HAS_ZERO  = 1'b1,
   parameter bit HAS_EARLY = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_we,
   input  logic              cfg_sel,
   input  logic              cfg_nonsec,
   input  logic [31:0]       cfg_wdata,
   output logic [31:0]       aux_q,
   output logic [LOCK_W-1:0] lock_q
);
   localparam logic [31:0] AUX_WMASK = aux_wmask_f(HAS_ZERO, HAS_EARLY);

   logic lock_wr_ok;
   assign lock_wr_ok = !cfg_nonsec || aux_q[AUX_NSLOCK_BIT];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         aux_q  <= '0;
         lock_q <= '0;
      end else if (cfg_we) begin
         if (!cfg_sel)
            aux_q <= cfg_wdata & AUX_WMASK;
         else if (lock_wr_ok)
            lock_q <= cfg_wdata[LOCK_W-1:0];
      end
   end

   // R11
   ns_lock_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_we && cfg_sel && cfg_nonsec && !aux_q[AUX_NSLOCK_BIT]) |=> $stable(lock_q));
endmodule

// File: rtl/wport_bchan.sv
module wport_bchan
   import wport_pkg::*;
#(
   parameter int ID_W = 4
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            push,
   input  logic [ID_W-1:0] push_id,
   input  logic            bready,
   output logic            bvalid,
   output logic [ID_W-1:0] bid,
   output logic [1:0]      bresp
);
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         bvalid <= 1'b0;
         bid    <= '0;
      end else if (push) begin
         bvalid <= 1'b1;
         bid    <= push_id;
      end else if (bvalid && bready) begin
         bvalid <= 1'b0;
      end
   end

   assign bresp = BRESP_OKAY;

   // R10
   no_double_push_chk: assert property (@(posedge clk) disable iff (!rst_n)
      push |-> !bvalid);

   // R9
   b_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (bvalid && !bready) |=> (bvalid && $stable(bid)));
endmodule

// File: rtl/wport_seq.sv
module wport_seq
   import wport_pkg::*;
#(
   parameter int ADDR_W     = 32,
   parameter int DATA_W     = 64,
   parameter int ID_W       = 4,
   parameter int USER_W     = 12,
   parameter int LINE_BYTES = 32
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                zero_en,
   input  logic                early_en,
   input  logic                awvalid,
   output logic                awready,
   input  logic [ID_W-1:0]     awid,
   input  logic [ADDR_W-1:0]   awaddr,
   input  logic [7:0]          awlen,
   input  logic [2:0]          awsize,
   input  logic [USER_W-1:0]   awuser,
   input  logic                wvalid,
   output logic                wready,
   input  logic [DATA_W-1:0]   wdata,
   input  logic [DATA_W/8-1:0] wstrb,
   input  logic                wlast,
   output logic                sb_valid,
   input  logic                sb_ready,
   output logic [1:0]          sb_op,
   output logic [ADDR_W-1:0]   sb_addr,
   output logic [DATA_W-1:0]   sb_data,
   output logic [DATA_W/8-1:0] sb_strb,
   input  logic                bvalid_i,
   output logic                push,
   output logic [ID_W-1:0]     push_id
);
   localparam int STRB_W   = DATA_W / 8;
   localparam int LINE_OFF = $clog2(LINE_BYTES);

   typedef enum logic [1:0] {ST_IDLE, ST_CMD, ST_DATA} st_e;

   st_e               state_q;
   logic [ID_W-1:0]   id_q;
   logic [ADDR_W-1:0] addr_q;
   logic [2:0]        size_q;
   logic [7:0]        len_q;
   logic [7:0]        beat_q;
   logic              zero_q;
   logic              early_q;

   logic              aw_hs;
   logic              w_hs;
   logic [ADDR_W-1:0] step;
   logic [ADDR_W-1:0] addr_next;
   logic [ADDR_W-1:0] line_addr;

   logic unused_user;
   assign unused_user = ^awuser;

   assign awready   = (state_q == ST_IDLE) && !bvalid_i;
   assign aw_hs     = awvalid && awready;
   assign w_hs      = wvalid && wready;
   assign step      = ADDR_W'(1) << size_q;
   assign addr_next = (addr_q & ~(step - ADDR_W'(1))) + step;
   assign line_addr = {addr_q[ADDR_W-1:LINE_OFF], LINE_OFF'(0)};

   always_comb begin
      sb_valid = 1'b0;
      sb_op    = SB_OPEN;
      sb_addr  = addr_q;
      sb_data  = '0;
      sb_strb  = '0;
      wready   = 1'b0;
      case (state_q)
         ST_CMD: begin
            sb_valid = 1'b1;
            if (zero_q) begin
               sb_op   = SB_ZERO;
               sb_addr = line_addr;
               sb_strb = {STRB_W{1'b1}};
            end
         end
         ST_DATA: begin
            if (zero_q) begin
               wready = 1'b1;
            end else begin
               sb_valid = wvalid;
               sb_op    = SB_BEAT;
               sb_data  = wdata;
               sb_strb  = wstrb;
               wready   = sb_ready;
            end
         end
         default: ;
      endcase
   end

   assign push    = ((state_q == ST_CMD) && sb_ready && early_q) ||
                    ((state_q == ST_DATA) && w_hs && wlast && !early_q);
   assign push_id = id_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         id_q    <= '0;
         addr_q  <= '0;
         size_q  <= '0;
         len_q   <= '0;
         beat_q  <= '0;
         zero_q  <= 1'b0;
         early_q <= 1'b0;
      end else begin
         case (state_q)
            ST_IDLE: if (aw_hs) begin
               state_q <= ST_CMD;
               id_q    <= awid;
               addr_q  <= awaddr;
               size_q  <= awsize;
               len_q   <= awlen;
               beat_q  <= '0;
               zero_q  <= zero_en && awuser[USR_ZERO_BIT];
               early_q <= early_en && awuser[USR_EARLY_BIT];
            end
            ST_CMD: if (sb_ready) state_q <= ST_DATA;
            ST_DATA: if (w_hs) begin
               beat_q <= beat_q + 8'd1;
               addr_q <= addr_next;
               if (wlast) state_q <= ST_IDLE;
            end
            default: state_q <= ST_IDLE;
         endcase
      end
   end

   // R12
   sb_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (sb_valid && !sb_ready) |=> (sb_valid && $stable(sb_op) && $stable(sb_addr)));

   // R6
   resp_after_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(bvalid_i) && !early_q) |-> $past(wvalid && wready && wlast));

   // R7
   early_resp_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(bvalid_i) && early_q) |-> $past(state_q == ST_CMD && sb_ready));

   // R5
   wlast_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ((state_q == ST_DATA) && w_hs) |-> (wlast == (beat_q == len_q)));
endmodule

// File: rtl/axi_wr_early_port.sv
module axi_wr_early_port
   import wport_pkg::*;
#(
   parameter int ADDR_W     = 32,
   parameter int DATA_W     = 64,
   parameter int ID_W       = 4,
   parameter int USER_W     = 12,
   parameter int LINE_BYTES = 32,
   parameter int LOCK_W     = 16,
   parameter bit HAS_ZERO   = 1'b1,
   parameter bit HAS_EARLY  = 1'b1
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                cfg_we,
   input  logic                cfg_sel,
   input  logic                cfg_nonsec,
   input  logic [31:0]         cfg_wdata,
   output logic [31:0]         aux_ctrl,
   output logic [LOCK_W-1:0]   lockdown,
   input  logic                awvalid,
   output logic                awready,
   input  logic [ID_W-1:0]     awid,
   input  logic [ADDR_W-1:0]   awaddr,
   input  logic [7:0]          awlen,
   input  logic [2:0]          awsize,
   input  logic [USER_W-1:0]   awuser,
   input  logic                wvalid,
   output logic                wready,
   input  logic [DATA_W-1:0]   wdata,
   input  logic [DATA_W/8-1:0] wstrb,
   input  logic                wlast,
   output logic                bvalid,
   input  logic                bready,
   output logic [ID_W-1:0]     bid,
   output logic [1:0]          bresp,
   output logic                sb_valid,
   input  logic                sb_ready,
   output logic [1:0]          sb_op,
   output logic [ADDR_W-1:0]   sb_addr,
   output logic [DATA_W-1:0]   sb_data,
   output logic [DATA_W/8-1:0] sb_strb
);
   localparam int STRB_W = DATA_W / 8;

   generate
      if (USER_W <= USR_EARLY_BIT) begin : g_bad_user
         $error("USER_W too narrow for request bits");
      end
      if ((DATA_W % 8) != 0 || DATA_W < 8) begin : g_bad_data
         $error("DATA_W must be a whole number of bytes");
      end
      if (LINE_BYTES < STRB_W || (LINE_BYTES & (LINE_BYTES - 1)) != 0) begin : g_bad_line
         $error("LINE_BYTES must be a power of two no smaller than a beat");
      end
      if (LOCK_W < 1 || LOCK_W > 32) begin : g_bad_lock
         $error("LOCK_W must be 1 to 32");
      end
   endgenerate

   logic            push;
   logic [ID_W-1:0] push_id;

   wport_cfg_regs #(
      .LOCK_W(LOCK_W), .HAS_ZERO(HAS_ZERO), .HAS_EARLY(HAS_EARLY)
   ) u_regs (
      .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
      .cfg_nonsec(cfg_nonsec), .cfg_wdata(cfg_wdata),
      .aux_q(aux_ctrl), .lock_q(lockdown)
   );

   wport_seq #(
      .ADDR_W(ADDR_W), .DATA_W(DATA_W), .ID_W(ID_W),
      .USER_W(USER_W), .LINE_BYTES(LINE_BYTES)
   ) u_seq (
      .clk(clk), .rst_n(rst_n),
      .zero_en(aux_ctrl[AUX_ZERO_BIT]), .early_en(aux_ctrl[AUX_EARLY_BIT]),
      .awvalid(awvalid), .awready(awready), .awid(awid), .awaddr(awaddr),
      .awlen(awlen), .awsize(awsize), .awuser(awuser),
      .wvalid(wvalid), .wready(wready), .wdata(wdata), .wstrb(wstrb), .wlast(wlast),
      .sb_valid(sb_valid), .sb_ready(sb_ready), .sb_op(sb_op), .sb_addr(sb_addr),
      .sb_data(sb_data), .sb_strb(sb_strb),
      .bvalid_i(bvalid), .push(push), .push_id(push_id)
   );

   wport_bchan #(.ID_W(ID_W)) u_bchan (
      .clk(clk), .rst_n(rst_n), .push(push), .push_id(push_id),
      .bready(bready), .bvalid(bvalid), .bid(bid), .bresp(bresp)
   );
endmodule

// File: tb/tb_axi_wr_early_port.sv
`timescale 1ns/100ps
module tb_axi_wr_early_port;
   localparam int ADDR_W = 32, DATA_W = 64, ID_W = 4, USER_W = 12, LOCK_W = 16;
   localparam int STRB_W = DATA_W / 8;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic cfg_we = 1'b0, cfg_sel = 1'b0, cfg_nonsec = 1'b0;
   logic [31:0] cfg_wdata = '0;
   logic [31:0] aux_ctrl;
   logic [LOCK_W-1:0] lockdown;
   logic awvalid = 1'b0, awready;
   logic [ID_W-1:0] awid = '0;
   logic [ADDR_W-1:0] awaddr = '0;
   logic [7:0] awlen = '0;
   logic [2:0] awsize = '0;
   logic [USER_W-1:0] awuser = '0;
   logic wvalid = 1'b0, wready, wlast = 1'b0;
   logic [DATA_W-1:0] wdata = '0;
   logic [STRB_W-1:0] wstrb = '0;
   logic bvalid, bready;
   logic [ID_W-1:0] bid;
   logic [1:0] bresp;
   logic sb_valid, sb_ready;
   logic [1:0] sb_op;
   logic [ADDR_W-1:0] sb_addr;
   logic [DATA_W-1:0] sb_data;
   logic [STRB_W-1:0] sb_strb;

   always #2.5 clk = ~clk;

   axi_wr_early_port dut (
      .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
      .cfg_nonsec(cfg_nonsec), .cfg_wdata(cfg_wdata), .aux_ctrl(aux_ctrl),
      .lockdown(lockdown), .awvalid(awvalid), .awready(awready), .awid(awid),
      .awaddr(awaddr), .awlen(awlen), .awsize(awsize), .awuser(awuser),
      .wvalid(wvalid), .wready(wready), .wdata(wdata), .wstrb(wstrb), .wlast(wlast),
      .bvalid(bvalid), .bready(bready), .bid(bid), .bresp(bresp),
      .sb_valid(sb_valid), .sb_ready(sb_ready), .sb_op(sb_op), .sb_addr(sb_addr),
      .sb_data(sb_data), .sb_strb(sb_strb)
   );

   int checks = 0, fails = 0;
   int sb_pct = 100, b_pct = 100;
   logic [31:0] model_aux = '0;
   logic [LOCK_W-1:0] model_lock = '0;

   // monitor state
   int cyc = 0, cmd_cyc = -1, wl_cyc = -1, bfirst_cyc = -1, bhs_cnt = 0, wcnt = 0;
   int busy_viol = 0;
   bit txn_open = 0;
   logic [ID_W-1:0] bid_seen;
   logic [1:0] bresp_seen;
   logic [1:0] m_op[$];
   logic [ADDR_W-1:0] m_addr[$];
   logic [DATA_W-1:0] m_data[$];
   logic [STRB_W-1:0] m_strb[$];
   logic [DATA_W-1:0] e_data[$];
   logic [STRB_W-1:0] e_strb[$];

   task automatic chk(input bit ok, input string req, input string what,
                      input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   function automatic logic [ADDR_W-1:0] next_beat(input logic [ADDR_W-1:0] a, input int sz);
      logic [ADDR_W-1:0] st;
      st = ADDR_W'(1) << sz;
      return (a & ~(st - 1)) + st;
   endfunction

   // Ready generation and handshake observation; the R12 hold rule lets
   // random sb_ready stalls still yield an exact command stream.
   always begin
      @(negedge clk);
      sb_ready = ($urandom_range(99) < sb_pct);
      bready   = ($urandom_range(99) < b_pct);
      #2;
      if (rst_n) begin
         cyc++;
         if (txn_open && awready) busy_viol++;
         if (awvalid && awready) txn_open = 1;
         if (sb_valid && sb_ready) begin
            m_op.push_back(sb_op); m_addr.push_back(sb_addr);
            m_data.push_back(sb_data); m_strb.push_back(sb_strb);
            if (sb_op != 2'd1) cmd_cyc = cyc;
         end
         if (wvalid && wready) wcnt++;
         if (wvalid && wready && wlast) wl_cyc = cyc;
         if (bvalid && bfirst_cyc < 0) bfirst_cyc = cyc;
         if (bvalid && bready) begin
            bhs_cnt++; bid_seen = bid; bresp_seen = bresp;
         end
         if (txn_open && wl_cyc >= 0 && bhs_cnt > 0) txn_open = 0;
      end
   end

   initial begin
      repeat (150000) @(posedge clk);
      fails++;
      $display("FAIL R10 watchdog actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

   task automatic cfg_write(input logic sel, input logic ns, input logic [31:0] d);
      @(negedge clk);
      cfg_we = 1'b1; cfg_sel = sel; cfg_nonsec = ns; cfg_wdata = d;
      @(negedge clk);
      cfg_we = 1'b0;
      if (!sel) model_aux = d;
      else if (!ns || model_aux[26]) model_lock = d[LOCK_W-1:0];
      #1;
   endtask

   task automatic run_txn(input logic [ID_W-1:0] id, input logic [ADDR_W-1:0] addr,
                          input int len, input int size, input logic [USER_W-1:0] user,
                          input int wdelay);
      bit ez, ee;
      logic [ADDR_W-1:0] ea;
      ez = model_aux[0] && user[10];
      ee = model_aux[30] && user[11];
      m_op.delete(); m_addr.delete(); m_data.delete(); m_strb.delete();
      e_data.delete(); e_strb.delete();
      cmd_cyc = -1; wl_cyc = -1; bfirst_cyc = -1; bhs_cnt = 0; wcnt = 0;
      fork
         begin
            @(negedge clk);
            awvalid = 1'b1; awid = id; awaddr = addr; awlen = 8'(len);
            awsize = 3'(size); awuser = user;
            #1;
            while (!awready) begin @(negedge clk); #1; end
            @(negedge clk);
            awvalid = 1'b0;
         end
         begin
            repeat (wdelay) @(negedge clk);
            for (int i = 0; i <= len; i++) begin
               @(negedge clk);
               wvalid = 1'b1;
               wdata = {$urandom, $urandom};
               wstrb = STRB_W'($urandom);
               wlast = (i == len);
               e_data.push_back(wdata); e_strb.push_back(wstrb);
               #1;
               while (!wready) begin @(negedge clk); #1; end
            end
            @(negedge clk);
            wvalid = 1'b0; wlast = 1'b0;
         end
      join
      while (!(bhs_cnt > 0 && wl_cyc >= 0)) @(negedge clk);
      repeat (3) @(negedge clk);
      #3;
      if (ez) begin
         chk(m_op.size() == 1, "R3", "zero cmd count", 64'(m_op.size()), 64'd1);
         if (m_op.size() >= 1) begin
            chk(m_op[0] == 2'd2, "R3", "zero op", 64'(m_op[0]), 64'd2);
            chk(m_addr[0] == (addr & ~32'h1F), "R3", "zero addr", 64'(m_addr[0]), 64'(addr & ~32'h1F));
            chk(m_data[0] == '0 && m_strb[0] == '1, "R3", "zero data/strb",
                64'(m_strb[0]), 64'hFF);
         end
         chk(wcnt == len + 1, "R4", "zero beats drained", 64'(wcnt), 64'(len + 1));
      end else begin
         chk(m_op.size() == len + 2, "R5", "cmd count", 64'(m_op.size()), 64'(len + 2));
         if (m_op.size() == len + 2) begin
            chk(m_op[0] == 2'd0 && m_addr[0] == addr, "R5", "open cmd", 64'(m_addr[0]), 64'(addr));
            ea = addr;
            for (int i = 0; i <= len; i++) begin
               chk(m_op[i+1] == 2'd1, "R5", "beat op", 64'(m_op[i+1]), 64'd1);
               chk(m_addr[i+1] == ea, "R5", "beat addr", 64'(m_addr[i+1]), 64'(ea));
               chk(m_data[i+1] == e_data[i] && m_strb[i+1] == e_strb[i], "R5", "beat data",
                   m_data[i+1], e_data[i]);
               ea = next_beat(ea, size);
            end
         end
      end
      if (ee)
         chk(bfirst_cyc == cmd_cyc + 1, "R7", "early resp cycle", 64'(bfirst_cyc), 64'(cmd_cyc + 1));
      else
         chk(bfirst_cyc == wl_cyc + 1, "R6", "resp after last", 64'(bfirst_cyc), 64'(wl_cyc + 1));
      chk(bhs_cnt == 1, "R7", "single response", 64'(bhs_cnt), 64'd1);
      chk(bid_seen == id, "R9", "bid", 64'(bid_seen), 64'(id));
      chk(bresp_seen == 2'b00, "R9", "bresp", 64'(bresp_seen), 64'd0);
   endtask

   initial begin
      void'($urandom(32'h1BADF00D));
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk); #1;
      // R1 reset state
      chk(aux_ctrl == 32'h0, "R1", "aux reset", 64'(aux_ctrl), 64'd0);
      chk(lockdown == '0, "R1", "lock reset", 64'(lockdown), 64'd0);
      chk(!bvalid, "R1", "bvalid reset", 64'(bvalid), 64'd0);
      chk(awready, "R1", "awready reset", 64'(awready), 64'd1);

      // R2 aux readback
      cfg_write(1'b0, 1'b1, 32'h4400_0001);
      chk(aux_ctrl == model_aux, "R2", "aux readback", 64'(aux_ctrl), 64'(model_aux));
      // R11 lockdown gating
      cfg_write(1'b0, 1'b0, 32'h0);
      cfg_write(1'b1, 1'b0, 32'h0000_00AB);
      chk(lockdown == 16'h00AB, "R11", "secure lock write", 64'(lockdown), 64'hAB);
      cfg_write(1'b1, 1'b1, 32'h0000_1234);
      chk(lockdown == 16'h00AB, "R11", "ns lock write blocked", 64'(lockdown), 64'hAB);
      cfg_write(1'b0, 1'b0, 32'h0400_0000);
      cfg_write(1'b1, 1'b1, 32'h0000_5678);
      chk(lockdown == model_lock && model_lock == 16'h5678, "R11", "ns lock write allowed",
          64'(lockdown), 64'h5678);

      // R5/R6 plain burst, then R8 user bits with enables cleared
      cfg_write(1'b0, 1'b0, 32'h0);
      run_txn(4'h3, 32'h0000_1008, 3, 3, 12'h000, 0);
      run_txn(4'h5, 32'h0000_2003, 2, 0, 12'hC00, 2);   // R8
      // R3/R4 zero, normal response; then zero with early response
      cfg_write(1'b0, 1'b0, 32'h4000_0001);
      run_txn(4'h7, 32'h1234_567B, 2, 1, 12'h400, 0);
      run_txn(4'h8, 32'h0000_003F, 3, 3, 12'hC00, 6);
      // R7 early response on a normal burst with late data
      run_txn(4'h9, 32'h0000_4010, 1, 2, 12'h800, 8);
      // R8 only one enable set
      cfg_write(1'b0, 1'b0, 32'h0000_0001);
      run_txn(4'hA, 32'h0000_5000, 1, 3, 12'h800, 3);

      for (int t = 0; t < 60; t++) begin
         if ((t % 8) == 0)
            cfg_write(1'b0, 1'b0, ($urandom_range(1) ? 32'h1 : 32'h0) |
                                  ($urandom_range(1) ? 32'h4000_0000 : 32'h0));
         sb_pct = $urandom_range(100, 30);
         b_pct  = $urandom_range(100, 30);
         run_txn(ID_W'($urandom), $urandom, $urandom_range(3), $urandom_range(3),
                 USER_W'($urandom), $urandom_range(5));
      end
      sb_pct = 100; b_pct = 100;

      // R10 no address acceptance while a transaction was open
      chk(busy_viol == 0, "R10", "awready while open", 64'(busy_viol), 64'd0);

      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end
endmodule